// File: doc/BRIEF.md
# Serial Configuration Access Slave

This block is a serial-peripheral slave that lets a host processor reach a bank of 16-bit control registers and a set of coefficient memories over four wires. Every transaction opens with a falling chip select, then a 16-bit instruction word, then one or more 16-bit data words. Both directions shift most significant bit first. The serial clock idles low. The host samples `miso_o` on the rising serial clock edge, and the slave changes `miso_o` only after a falling edge.

The serial clock, chip select and data input pass through synchronisers into the system clock domain, where the transfer is decoded. Each serial clock half-period must last at least four system clock cycles. Register contents are driven out continuously on `cfg_regs_o` for the logic they configure. The coefficient memories live outside the block and are reached through a simple port: one-cycle write strobes, and read strobes whose data is returned one cycle later. Memory transfers stream through consecutive addresses until chip select rises. Register transfers always carry exactly one data word.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, every register reads zero on `cfg_regs_o`, `miso_o` is low, and no memory write strobe is issued.
- R2: An instruction with bits 15:13 = 100 writes the following data word into the register addressed by instruction bits 12:8. The write lands once the 32nd bit has been received.
- R3: An instruction with bits 15:13 = 010 returns the addressed register on `miso_o` during the next 16 clocks, MSB first, with each bit updated after a falling serial clock edge.
- R4: An instruction with bits 15:13 = 101 writes each complete data word to the memory bank given by instruction bits 9:8, at the word address taken from bits 7:0. Each word produces exactly one `mem_we_o` pulse.
- R5: An instruction with bits 15:13 = 011 returns memory data on `miso_o`. The word is taken from `mem_rdata_i` one system cycle after `mem_re_o`.
- R6: Memory transfers continue as a burst while chip select stays low, and the address increments by one per word, wrapping from 255 to 0.
- R7: A rising chip select ends the transfer at once. A data word with fewer than 16 bits received is discarded.
- R8: Register addresses 13 to 31 read as zero, and writes to them change no register.
- R9: Bank select 3 is unmapped: it raises no memory strobe, and reads from it return zero.
- R10: An instruction whose bits 15:13 match none of the four operations is ignored. Its data words write nothing, and `miso_o` stays low.
- R11: `miso_o` is low while chip select is high and throughout the instruction word.
- R12: A register access uses only one data word. Further words in the same transfer write nothing and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| cfg_regs_o | output | NUM_REGS*16 | All control registers, register k in bits 16k+15:16k |
| mem_we_o | output | 1 | Coefficient memory write strobe |
| mem_re_o | output | 1 | Coefficient memory read strobe |
| mem_bank_o | output | 2 | Memory bank select |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the read strobe |

## Verification
Some properties are checked on every cycle by the assertions. The register file and the memory port each receive at most one strobe per cycle, and a strobe appears only when a word has just completed. No strobe ever targets an unmapped bank. A write to an unmapped register leaves the register file unchanged. `miso_o` moves only after a falling serial clock edge.

Other behaviours only the bench scenarios can show. These are the bit order of read data, address wrap within a burst, loss of a truncated final word, unknown opcodes being dropped, and extra words after a register access being ignored. Each is checked against a memory image and a register image that the bench keeps itself.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int WORD_W     = 16;
  localparam int REG_ADDR_W = 5;
  localparam int BANK_W     = 2;
  localparam int MEM_ADDR_W = 8;

  // operation field, instruction bits 15:13
  localparam logic [2:0] OP_REG_WR = 3'b100;
  localparam logic [2:0] OP_MEM_WR = 3'b101;
  localparam logic [2:0] OP_REG_RD = 3'b010;
  localparam logic [2:0] OP_MEM_RD = 3'b011;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_SKIP  = 2'd2
  } phase_e;

  typedef struct packed {
    logic                  valid;
    logic                  is_wr;
    logic                  is_reg;
    logic [REG_ADDR_W-1:0] raddr;
    logic [BANK_W-1:0]     bank;
    logic [MEM_ADDR_W-1:0] maddr;
  } instr_t;

  function automatic instr_t decode_instr(input logic [WORD_W-1:0] w);
    instr_t r;
    logic [2:0] op;
    op       = w[15:13];
    r.valid  = (op == OP_REG_WR) || (op == OP_MEM_WR) ||
               (op == OP_REG_RD) || (op == OP_MEM_RD);
    r.is_wr  = op[2];
    r.is_reg = ~op[0];
    r.raddr  = w[12:8];
    r.bank   = w[9:8];
    r.maddr  = w[7:0];
    return r;
  endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_active_o,
  output logic mosi_o
);

  logic [STAGES-1:0] sclk_q, sclk_d;
  logic [STAGES-1:0] cs_q, cs_d;
  logic [STAGES-1:0] mosi_q, mosi_d;
  logic              sclk_last_q;

  always_comb begin
    sclk_d = {sclk_q[STAGES-2:0], sclk_i};
    cs_d   = {cs_q[STAGES-2:0], cs_n_i};
    mosi_d = {mosi_q[STAGES-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      cs_q        <= '1;
      mosi_q      <= '0;
      sclk_last_q <= 1'b0;
    end else begin
      sclk_q      <= sclk_d;
      cs_q        <= cs_d;
      mosi_q      <= mosi_d;
      sclk_last_q <= sclk_q[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_last_q;
  assign sclk_fall_o = ~sclk_q[STAGES-1] & sclk_last_q;
  assign cs_active_o = ~cs_q[STAGES-1];
  assign mosi_o      = mosi_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_active_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         mosi_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_word_i,
  output logic         word_done_o,
  output logic [W-1:0] rx_word_o,
  output logic         miso_o
);

  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [W-1:0]     tx_q, tx_d;
  logic             miso_q, miso_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    done_d = 1'b0;
    if (!cs_active_i) begin
      cnt_d  = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (sclk_rise_i) begin
        rx_d   = {rx_q[W-2:0], mosi_i};
        done_d = (cnt_q == CNT_W'(W-1));
        cnt_d  = (cnt_q == CNT_W'(W-1)) ? '0 : cnt_q + 1'b1;
      end
      if (load_en_i) begin
        tx_d = load_word_i;
      end else if (sclk_fall_i) begin
        miso_d = tx_q[W-1];
        tx_d   = {tx_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
      done_q <= done_d;
    end
  end

  assign word_done_o = done_q;
  assign rx_word_o   = rx_q;
  assign miso_o      = miso_q;

  // R3: while selected, the output bit moves only after a falling serial edge
  assert_miso_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_active_i) && cs_active_i && !$past(sclk_fall_i)) |-> $stable(miso_o));

endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_active_i,
  input  logic                  word_done_i,
  input  logic [WORD_W-1:0]     rx_word_i,
  input  logic [WORD_W-1:0]     reg_rdata_i,
  input  logic [WORD_W-1:0]     mem_rdata_i,
  output logic                  reg_we_o,
  output logic [REG_ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0]     reg_wdata_o,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  output logic [BANK_W-1:0]     mem_bank_o,
  output logic [MEM_ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]     mem_wdata_o,
  output logic                  load_en_o,
  output logic [WORD_W-1:0]     load_word_o
);

  phase_e                phase_q, phase_d;
  instr_t                ins_q, ins_d, dec;
  logic [MEM_ADDR_W-1:0] addr_q, addr_d;
  logic                  rd_pend_q, rd_pend_d;

  function automatic logic bank_ok(input logic [BANK_W-1:0] b);
    return int'(b) < NUM_BANKS;
  endfunction

  assign dec = decode_instr(rx_word_i);

  always_comb begin
    phase_d     = phase_q;
    ins_d       = ins_q;
    addr_d      = addr_q;
    rd_pend_d   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = ins_q.raddr;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_bank_o  = ins_q.bank;
    mem_addr_o  = addr_q;
    load_en_o   = 1'b0;
    load_word_o = '0;
    if (rd_pend_q) begin
      load_en_o   = 1'b1;
      load_word_o = mem_rdata_i;
    end
    if (!cs_active_i) begin
      phase_d = PH_INSTR;
    end else if (word_done_i) begin
      unique case (phase_q)
        PH_INSTR: begin
          reg_addr_o = dec.raddr;
          mem_bank_o = dec.bank;
          mem_addr_o = dec.maddr;
          if (dec.valid) begin
            ins_d   = dec;
            addr_d  = dec.maddr;
            phase_d = PH_DATA;
            if (!dec.is_wr) begin
              if (dec.is_reg || !bank_ok(dec.bank)) begin
                load_en_o   = 1'b1;
                load_word_o = dec.is_reg ? reg_rdata_i : '0;
              end else begin
                mem_re_o  = 1'b1;
                rd_pend_d = 1'b1;
              end
            end
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_DATA: begin
          if (ins_q.is_reg) begin
            phase_d  = PH_SKIP;
            reg_we_o = ins_q.is_wr;
          end else begin
            addr_d = addr_q + 1'b1;
            if (ins_q.is_wr) begin
              mem_we_o = bank_ok(ins_q.bank);
            end else if (bank_ok(ins_q.bank)) begin
              mem_addr_o = addr_q + 1'b1;
              mem_re_o   = 1'b1;
              rd_pend_d  = 1'b1;
            end else begin
              load_en_o   = 1'b1;
              load_word_o = '0;
            end
          end
        end
        default: phase_d = PH_SKIP;
      endcase
    end
  end

  assign reg_wdata_o = rx_word_i;
  assign mem_wdata_o = rx_word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_INSTR;
      ins_q     <= '0;
      addr_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      ins_q     <= ins_d;
      addr_q    <= addr_d;
      rd_pend_q <= rd_pend_d;
    end
  end

  // R2: a register write happens only on a freshly completed word
  assert_reg_we_on_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> word_done_i);

  // R4: at most one strobe of any kind per cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we_o, mem_re_o, reg_we_o}));

  // R9: no memory strobe ever addresses an unmapped bank
  assert_bank_mapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> (int'(mem_bank_o) < NUM_BANKS));

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile #(
  parameter int NUM_REGS = 13,
  parameter int W        = 16,
  parameter int AW       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [W-1:0]          rdata_o,
  output logic [NUM_REGS*W-1:0] regs_o
);

  logic [W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wdata_i;
      end
    end
    assign regs_o[g*W +: W] = regs_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == AW'(i)) rdata_o = regs_q[i];
    end
  end

  // R8: writes beyond the last register leave the file unchanged
  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (int'(addr_i) >= NUM_REGS)) |=> $stable(regs_o));

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 13,
  parameter int NUM_BANKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_i,
  input  logic                       cs_n_i,
  input  logic                       mosi_i,
  output logic                       miso_o,
  output logic [NUM_REGS*WORD_W-1:0] cfg_regs_o,
  output logic                       mem_we_o,
  output logic                       mem_re_o,
  output logic [BANK_W-1:0]          mem_bank_o,
  output logic [MEM_ADDR_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]          mem_wdata_o,
  input  logic [WORD_W-1:0]          mem_rdata_i
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic                  sclk_rise, sclk_fall, cs_active, mosi_s;
  logic                  word_done, load_en;
  logic [WORD_W-1:0]     rx_word, load_word;
  logic                  reg_we;
  logic [REG_ADDR_W-1:0] reg_addr;
  logic [WORD_W-1:0]     reg_wdata, reg_rdata;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sclk_i      (sclk_i),
    .cs_n_i      (cs_n_i),
    .mosi_i      (mosi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_active_o (cs_active),
    .mosi_o      (mosi_s)
  );

  spi_cfg_shifter #(.W(WORD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_active_i (cs_active),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .mosi_i      (mosi_s),
    .load_en_i   (load_en),
    .load_word_i (load_word),
    .word_done_o (word_done),
    .rx_word_o   (rx_word),
    .miso_o      (miso_o)
  );

  spi_cfg_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_active_i (cs_active),
    .word_done_i (word_done),
    .rx_word_i   (rx_word),
    .reg_rdata_i (reg_rdata),
    .mem_rdata_i (mem_rdata_i),
    .reg_we_o    (reg_we),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_bank_o  (mem_bank_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .load_en_o   (load_en),
    .load_word_o (load_word)
  );

  spi_cfg_regfile #(.NUM_REGS(NUM_REGS), .W(WORD_W), .AW(REG_ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .regs_o  (cfg_regs_o)
  );

endmodule

// File: tb/spi_cfg_slave_tb_top.sv
module spi_cfg_slave_tb_top;

  localparam int NREG = 13;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NREG*16-1:0] cfg_regs;
  logic mem_we, mem_re;
  logic [1:0] mem_bank;
  logic [7:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  spi_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .cfg_regs_o(cfg_regs), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_bank_o(mem_bank), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  logic [15:0] mem_model [0:3][0:255];
  logic [15:0] exp_mem   [0:3][0:255];
  logic [15:0] exp_regs  [0:NREG-1];
  logic [15:0] txw [0:15];
  logic [15:0] rxw [0:15];
  int we_count = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem_model[mem_bank][mem_addr] <= mem_wdata;
      we_count <= we_count + 1;
    end
    if (mem_re) mem_rdata <= mem_model[mem_bank][mem_addr];
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg_rd(input int a);
    return (a < NREG) ? exp_regs[a] : 16'h0000;
  endfunction

  task automatic spi_word(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      repeat (HP) @(negedge clk);
      r = {r[14:0], miso};
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input int nwords, input int last_bits);
    logic [15:0] r;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = 0; k < nwords; k++) begin
      spi_word(txw[k], (k == nwords-1) ? last_bits : 16, r);
      rxw[k] = r;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [15:0] d);
    txw[0] = {3'b100, 5'(a), 8'h00};
    txw[1] = d;
    xfer(2, 16);
    if (a < NREG) exp_regs[a] = d;
  endtask

  task automatic reg_read(input int a, input string req);
    txw[0] = {3'b010, 5'(a), 8'h00};
    txw[1] = 16'h0000;
    xfer(2, 16);
    check("R11 instruction-phase miso", rxw[0], 16'h0000);
    check(req, rxw[1], exp_reg_rd(a));
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) check(req, cfg_regs[i*16 +: 16], exp_regs[i]);
  endtask

  task automatic mem_write(input int b, input int a, input int n);
    txw[0] = {3'b101, 3'b000, 2'(b), 8'(a)};
    for (int k = 0; k < n; k++) begin
      txw[k+1] = 16'($urandom);
      if (b < 3) exp_mem[b][(a+k) % 256] = txw[k+1];
    end
    xfer(n+1, 16);
  endtask

  task automatic mem_read(input int b, input int a, input int n, input string req);
    txw[0] = {3'b011, 3'b000, 2'(b), 8'(a)};
    for (int k = 0; k < n; k++) txw[k+1] = 16'hFFFF;
    xfer(n+1, 16);
    check("R11 instruction-phase miso", rxw[0], 16'h0000);
    for (int k = 0; k < n; k++)
      check(req, rxw[k+1], (b < 3) ? exp_mem[b][(a+k) % 256] : 16'h0000);
  endtask

  task automatic check_mem(input int b, input int a, input int n, input string req);
    for (int k = 0; k < n; k++)
      check(req, mem_model[b][(a+k) % 256], exp_mem[b][(a+k) % 256]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int wc;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 256; i++) begin
        mem_model[b][i] = 16'(b*4096 + i*37);
        exp_mem[b][i]   = 16'(b*4096 + i*37);
      end
    for (int i = 0; i < NREG; i++) exp_regs[i] = 16'h0000;
    mem_rdata = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: reset state
    check_regs("R1 reset register value");
    check("R1 reset miso", {15'b0, miso}, 16'h0000);
    check("R1 no write strobe", 16'(we_count), 16'h0000);

    // R2 / R3: directed register write and readback
    reg_write(0, 16'hA5C3);
    reg_write(12, 16'h1234);
    check_regs("R2 register write");
    reg_read(0, "R3 register read");
    reg_read(12, "R3 register read");

    // R8: unmapped register addresses
    reg_write(20, 16'hDEAD);
    check_regs("R8 unmapped write ignored");
    reg_read(20, "R8 unmapped read zero");
    reg_read(31, "R8 unmapped read zero");

    // R7: truncated register write
    txw[0] = {3'b100, 5'd3, 8'h00};
    txw[1] = 16'hBEEF;
    xfer(2, 10);
    check_regs("R7 truncated register write discarded");

    // R10: unknown opcodes
    txw[0] = {3'b111, 5'd2, 8'h00}; txw[1] = 16'h7777; txw[2] = 16'h8888;
    xfer(3, 16);
    check_regs("R10 unknown opcode writes nothing");
    check("R10 unknown opcode miso", rxw[1] | rxw[2], 16'h0000);
    wc = we_count;
    txw[0] = {3'b001, 3'b000, 2'd0, 8'd5}; txw[1] = 16'h1111;
    xfer(2, 16);
    check("R10 unknown opcode no memory write", 16'(we_count - wc), 16'h0000);
    check("R10 unknown opcode miso", rxw[1], 16'h0000);

    // R12: extra words after a register access
    txw[0] = {3'b100, 5'd4, 8'h00}; txw[1] = 16'h4444; txw[2] = 16'h5555;
    xfer(3, 16);
    exp_regs[4] = 16'h4444;
    check_regs("R12 extra write word ignored");
    txw[0] = {3'b010, 5'd4, 8'h00}; txw[1] = 16'h0; txw[2] = 16'h0; txw[3] = 16'h0;
    xfer(4, 16);
    check("R12 register read word", rxw[1], 16'h4444);
    check("R12 extra read words zero", rxw[2] | rxw[3], 16'h0000);

    // R4 / R5: single memory access
    wc = we_count;
    mem_write(0, 10, 1);
    check("R4 one strobe per word", 16'(we_count - wc), 16'h0001);
    check_mem(0, 10, 1, "R4 memory write");
    mem_read(0, 10, 1, "R5 memory read");
    mem_read(2, 200, 2, "R5 memory read");

    // R6: burst with address wrap
    wc = we_count;
    mem_write(1, 254, 4);
    check("R6 burst strobe count", 16'(we_count - wc), 16'h0004);
    check_mem(1, 254, 4, "R6 burst write wrap");
    mem_read(1, 254, 4, "R6 burst read wrap");

    // R7: truncated final word of a memory burst
    wc = we_count;
    txw[0] = {3'b101, 3'b000, 2'd2, 8'd50};
    txw[1] = 16'h0101; txw[2] = 16'h0202; txw[3] = 16'h0303;
    xfer(4, 7);
    exp_mem[2][50] = 16'h0101; exp_mem[2][51] = 16'h0202;
    check("R7 truncated burst strobe count", 16'(we_count - wc), 16'h0002);
    check_mem(2, 50, 3, "R7 truncated burst contents");

    // R9: unmapped bank
    wc = we_count;
    mem_write(3, 7, 3);
    check("R9 unmapped bank no strobe", 16'(we_count - wc), 16'h0000);
    mem_read(3, 7, 3, "R9 unmapped bank read zero");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind, a, b, len;
      kind = int'($urandom % 4);
      a    = int'($urandom % 256);
      b    = int'($urandom % 4);
      len  = 1 + int'($urandom % 4);
      case (kind)
        0: begin reg_write(a % 32, 16'($urandom)); check_regs("R2 random register write"); end
        1: reg_read(a % 32, "R3 random register read");
        2: begin mem_write(b, a, len); if (b < 3) check_mem(b, a, len, "R4 random memory write"); end
        default: mem_read(b, a, len, "R6 random memory burst read");
      endcase
    end

    check("R11 miso idle", {15'b0, miso}, 16'h0000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule